// File: doc/BRIEF.md
# Scripted Bus Stimulus Sequencer

This block runs a stimulus script held in a small instruction memory and hands bus transactions, one at a time, to a transaction engine. Each script word is either a transaction (command code, address, data and the fault code the engine should expect), a timing or control step (halt marker, wait a number of bus cycles, jump, wait on a flag, skip on a flag), a flag write, or a setting (privilege mode bit, byte-lane select). One bus cycle is four clock edges.

Flag writes, flag tests that skip, jumps, settings and unknown opcodes take no bus time. Up to four of them are executed back to back in one clock cycle, and the sequencer then stops on the next word that takes time. An 8-bit flag register can also be set or cleared from outside through peer masks, so that several sequencers can wait on each other. The script memory is filled by direct initialisation; it has no write port.

Top module: `seqscript_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, txnValid, endSim, busMode, byteSel and syncFlags are all 0, and the program counter starts at word 0.
- R2: A script word is 48 bits wide. From the most significant bit down it holds: opcode (4 bits), flag index (3), engine command (4), expected fault (5), address (16) and data (16). Opcode 10 is a transaction. While the program counter points at it, txnValid is 1 and txnCmd, txnAddr, txnData and txnFault carry its fields. These stay stable until a clock edge at which txnDone is 1, and at that edge the sequencer moves to the next word.
- R3: Opcode 2 waits for a number of bus cycles N taken from the data field. It holds for 4·N clock edges, counted from a phase counter that is cleared whenever a word starts, and it advances on the edge after that. A transaction that directly follows a wait therefore appears 4·N+1 edges after the wait begins.
- R4: Opcode 6 waits on a flag. It advances only on an edge at which the named flag is 1 and a free-running 2-bit edge counter equals 3. That counter is 0 in reset and increases by 1 on every edge, so the release falls on edge numbers that are multiples of 4, counting from the first edge after reset.
- R5: Opcode 7 skips on a flag. It moves on by two words when the named flag is 1 and by one word otherwise.
- R6: Opcode 4 sets the named flag and opcode 5 clears it. Both take no bus time.
- R7: Opcode 8 loads busMode from data bit 0, and opcode 9 loads byteSel from data bits 3:0. Both take no bus time.
- R8: Opcode 1 is the halt marker. It raises endSim for exactly the one cycle in which it is current, and then advances to the next word.
- R9: Opcode 3 loads the program counter from the low bits of the data field. A jump to itself parks the sequencer with no further effect.
- R10: Any opcode not listed here, including 0, advances by one word with no effect on any output.
- R11: In one clock cycle, at most four zero-time words (opcodes 3, 4, 5, 7, 8, 9 and unknown) are executed. Each one sees the flag writes of the earlier ones in the same cycle, and the rest continue on the next cycle.
- R12: On each edge, flag bits in peerSet become 1 and flag bits in peerClr become 0. peerSet wins over peerClr, and both win over the script's own flag writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txnDone | input | 1 | Engine has accepted the current transaction |
| peerSet | input | 8 | Flag bits to set, from other sequencers |
| peerClr | input | 8 | Flag bits to clear, from other sequencers |
| txnValid | output | 1 | A transaction word is current |
| txnCmd | output | 4 | Engine command code |
| txnAddr | output | 16 | Transaction address |
| txnData | output | 16 | Write data or expected read data |
| txnFault | output | 5 | Expected fault code |
| endSim | output | 1 | Halt marker reached |
| busMode | output | 1 | Privilege mode setting |
| byteSel | output | 4 | Byte-lane select setting |
| syncFlags | output | 8 | Shared flag register |

## Verification
Transaction outputs follow the program counter through combinational logic. A new transaction is visible in the cycle right after the edge that moves the counter onto it, so the monitor records the edge number at which each one first appears. The bench then compares gaps between these edge numbers: 4 edges across a chain of exactly four zero-time words after a two-cycle stall, 4·N+1+1 edges across a wait, and the first multiple-of-4 edge after a peer flag set for the flag wait. Flag, mode and halt effects are registered on one edge and sampled half a cycle later, on the edge counts worked out from these same rules.

// File: rtl/seqscript_pkg.sv
package seqscript_pkg;
  parameter int OP_W    = 4;
  parameter int FLAG_N  = 8;
  parameter int FIDX_W  = $clog2(FLAG_N);
  parameter int CMD_W   = 4;
  parameter int FAULT_W = 5;
  parameter int ADDR_W  = 16;
  parameter int DATA_W  = 16;
  parameter int BSEL_W  = 4;
  parameter int EDGES_PER_BUS = 4;
  parameter int EC_W    = $clog2(EDGES_PER_BUS);
  parameter int PHASE_W = DATA_W + EC_W;
  parameter int INSN_W  = OP_W + FIDX_W + CMD_W + FAULT_W + ADDR_W + DATA_W;

  localparam logic [OP_W-1:0] OP_STOP  = 4'd1;
  localparam logic [OP_W-1:0] OP_WAIT  = 4'd2;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'd3;
  localparam logic [OP_W-1:0] OP_SETF  = 4'd4;
  localparam logic [OP_W-1:0] OP_CLRF  = 4'd5;
  localparam logic [OP_W-1:0] OP_WSYNC = 4'd6;
  localparam logic [OP_W-1:0] OP_SKIPT = 4'd7;
  localparam logic [OP_W-1:0] OP_MODE  = 4'd8;
  localparam logic [OP_W-1:0] OP_BSEL  = 4'd9;
  localparam logic [OP_W-1:0] OP_XACT  = 4'd10;

  typedef struct packed {
    logic [OP_W-1:0]    op;
    logic [FIDX_W-1:0]  fidx;
    logic [CMD_W-1:0]   cmd;
    logic [FAULT_W-1:0] fault;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  data;
  } insn_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              pcWe;
    logic              phaseInc;
    logic              phaseClr;
    logic [FLAG_N-1:0] flagsNext;
    logic              modeVal;
    logic [BSEL_W-1:0] bselVal;
  } ctl_strobe_t;

  // words that consume bus time stop the zero-time chain
  function automatic logic takesTime(input logic [OP_W-1:0] op);
    return (op == OP_STOP) || (op == OP_WAIT) || (op == OP_WSYNC) || (op == OP_XACT);
  endfunction
endpackage

// File: rtl/seqscript_step.sv
module seqscript_step
  import seqscript_pkg::*;
#(
  parameter int PC_W = 5
) (
  input  logic              liveIn,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [FLAG_N-1:0] flagsIn,
  input  logic              modeIn,
  input  logic [BSEL_W-1:0] bselIn,
  input  insn_t             word,
  output logic              liveOut,
  output logic [PC_W-1:0]   pcOut,
  output logic [FLAG_N-1:0] flagsOut,
  output logic              modeOut,
  output logic [BSEL_W-1:0] bselOut
);
  logic [PC_W-1:0] pcInc;
  assign pcInc = pcIn + PC_W'(1);

  always_comb begin
    liveOut  = 1'b0;
    pcOut    = pcIn;
    flagsOut = flagsIn;
    modeOut  = modeIn;
    bselOut  = bselIn;
    if (liveIn && !takesTime(word.op)) begin
      liveOut = 1'b1;
      pcOut   = pcInc;
      unique case (word.op)
        OP_JUMP:  pcOut = word.data[PC_W-1:0];
        OP_SETF:  flagsOut[word.fidx] = 1'b1;
        OP_CLRF:  flagsOut[word.fidx] = 1'b0;
        OP_SKIPT: if (flagsIn[word.fidx]) pcOut = pcInc + PC_W'(1);
        OP_MODE:  modeOut = word.data[0];
        OP_BSEL:  bselOut = word.data[BSEL_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/seqscript_dp.sv
module seqscript_dp
  import seqscript_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CHAIN = 4,
  parameter int PC_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   rdAddr [CHAIN],
  output insn_t             rdData [CHAIN],
  input  logic [PC_W-1:0]   pcNext,
  input  ctl_strobe_t       strobe,
  input  logic [FLAG_N-1:0] peerSet,
  input  logic [FLAG_N-1:0] peerClr,
  output logic [PC_W-1:0]   pc,
  output logic [PHASE_W-1:0] phase,
  output logic [EC_W-1:0]   edgeCnt,
  output logic [FLAG_N-1:0] flags,
  output logic              mode,
  output logic [BSEL_W-1:0] bsel
);
  insn_t progMem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) progMem[i] = '0;
  end

  for (genvar k = 0; k < CHAIN; k++) begin : g_port
    assign rdData[k] = progMem[rdAddr[k]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      phase   <= '0;
      edgeCnt <= '0;
      flags   <= '0;
      mode    <= 1'b0;
      bsel    <= '0;
    end else begin
      edgeCnt <= edgeCnt + EC_W'(1);
      if (strobe.pcWe) pc <= pcNext;
      if (strobe.phaseClr)      phase <= '0;
      else if (strobe.phaseInc) phase <= phase + PHASE_W'(1);
      flags <= (strobe.flagsNext & ~peerClr) | peerSet;
      mode  <= strobe.modeVal;
      bsel  <= strobe.bselVal;
    end
  end
endmodule

// File: rtl/seqscript_ctl.sv
module seqscript_ctl
  import seqscript_pkg::*;
#(
  parameter int CHAIN = 4,
  parameter int PC_W  = 5
) (
  input  insn_t              rdData [CHAIN],
  output logic [PC_W-1:0]    rdAddr [CHAIN],
  input  logic [PC_W-1:0]    pc,
  input  logic [PHASE_W-1:0] phase,
  input  logic [EC_W-1:0]    edgeCnt,
  input  logic [FLAG_N-1:0]  flags,
  input  logic               mode,
  input  logic [BSEL_W-1:0]  bsel,
  input  logic               txnDone,
  output logic [PC_W-1:0]    pcNext,
  output ctl_strobe_t        strobe,
  output logic               txnValid,
  output logic               endSim
);
  logic              stLive  [CHAIN+1];
  logic [PC_W-1:0]   stPc    [CHAIN+1];
  logic [FLAG_N-1:0] stFlags [CHAIN+1];
  logic              stMode  [CHAIN+1];
  logic [BSEL_W-1:0] stBsel  [CHAIN+1];

  assign stLive[0]  = 1'b1;
  assign stPc[0]    = pc;
  assign stFlags[0] = flags;
  assign stMode[0]  = mode;
  assign stBsel[0]  = bsel;

  for (genvar k = 0; k < CHAIN; k++) begin : g_step
    assign rdAddr[k] = stPc[k];
    seqscript_step #(.PC_W(PC_W)) u_step (
      .liveIn  (stLive[k]),
      .pcIn    (stPc[k]),
      .flagsIn (stFlags[k]),
      .modeIn  (stMode[k]),
      .bselIn  (stBsel[k]),
      .word    (rdData[k]),
      .liveOut (stLive[k+1]),
      .pcOut   (stPc[k+1]),
      .flagsOut(stFlags[k+1]),
      .modeOut (stMode[k+1]),
      .bselOut (stBsel[k+1])
    );
  end

  insn_t head;
  logic  advance;
  logic [PHASE_W-1:0] waitLimit;
  assign head      = rdData[0];
  assign waitLimit = PHASE_W'(head.data) << EC_W;

  always_comb begin
    strobe           = '0;
    strobe.flagsNext = flags;
    strobe.modeVal   = mode;
    strobe.bselVal   = bsel;
    pcNext   = pc + PC_W'(1);
    advance  = 1'b0;
    txnValid = 1'b0;
    endSim   = 1'b0;
    if (!takesTime(head.op)) begin
      strobe.pcWe      = 1'b1;
      strobe.phaseClr  = 1'b1;
      pcNext           = stPc[CHAIN];
      strobe.flagsNext = stFlags[CHAIN];
      strobe.modeVal   = stMode[CHAIN];
      strobe.bselVal   = stBsel[CHAIN];
    end else begin
      unique case (head.op)
        OP_STOP: begin
          endSim  = 1'b1;
          advance = 1'b1;
        end
        OP_WAIT: begin
          if (phase < waitLimit) strobe.phaseInc = 1'b1;
          else                   advance = 1'b1;
        end
        OP_WSYNC: advance = flags[head.fidx] && (edgeCnt == EC_W'(EDGES_PER_BUS - 1));
        default: begin
          txnValid = 1'b1;
          advance  = txnDone;
        end
      endcase
      strobe.pcWe     = advance;
      strobe.phaseClr = advance;
    end
  end
endmodule

// File: rtl/seqscript_top.sv
module seqscript_top
  import seqscript_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CHAIN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               txnDone,
  input  logic [FLAG_N-1:0]  peerSet,
  input  logic [FLAG_N-1:0]  peerClr,
  output logic               txnValid,
  output logic [CMD_W-1:0]   txnCmd,
  output logic [ADDR_W-1:0]  txnAddr,
  output logic [DATA_W-1:0]  txnData,
  output logic [FAULT_W-1:0] txnFault,
  output logic               endSim,
  output logic               busMode,
  output logic [BSEL_W-1:0]  byteSel,
  output logic [FLAG_N-1:0]  syncFlags
);
  localparam int PC_W = $clog2(DEPTH);

  logic [PC_W-1:0]    rdAddr [CHAIN];
  insn_t              rdData [CHAIN];
  logic [PC_W-1:0]    pcNow;
  logic [PC_W-1:0]    pcNext;
  logic [PHASE_W-1:0] phase;
  logic [EC_W-1:0]    edgeCnt;
  ctl_strobe_t        strobe;
  logic [OP_W-1:0]    headOp;

  assign headOp   = rdData[0].op;
  assign txnCmd   = rdData[0].cmd;
  assign txnAddr  = rdData[0].addr;
  assign txnData  = rdData[0].data;
  assign txnFault = rdData[0].fault;

  seqscript_dp #(.DEPTH(DEPTH), .CHAIN(CHAIN), .PC_W(PC_W)) u_dp (
    .clk(clk), .rst(rst), .rdAddr(rdAddr), .rdData(rdData),
    .pcNext(pcNext), .strobe(strobe), .peerSet(peerSet), .peerClr(peerClr),
    .pc(pcNow), .phase(phase), .edgeCnt(edgeCnt), .flags(syncFlags),
    .mode(busMode), .bsel(byteSel)
  );

  seqscript_ctl #(.CHAIN(CHAIN), .PC_W(PC_W)) u_ctl (
    .rdData(rdData), .rdAddr(rdAddr), .pc(pcNow), .phase(phase),
    .edgeCnt(edgeCnt), .flags(syncFlags), .mode(busMode), .bsel(byteSel),
    .txnDone(txnDone), .pcNext(pcNext), .strobe(strobe),
    .txnValid(txnValid), .endSim(endSim)
  );
endmodule

// File: rtl/seqscript_chk.sv
module seqscript_chk
  import seqscript_pkg::*;
#(
  parameter int PC_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               txnValid,
  input logic               txnDone,
  input logic [CMD_W-1:0]   txnCmd,
  input logic [ADDR_W-1:0]  txnAddr,
  input logic [DATA_W-1:0]  txnData,
  input logic [FAULT_W-1:0] txnFault,
  input logic               endSim,
  input logic [FLAG_N-1:0]  peerSet,
  input logic [FLAG_N-1:0]  peerClr,
  input logic [FLAG_N-1:0]  syncFlags,
  input logic [OP_W-1:0]    headOp,
  input logic [PC_W-1:0]    pcNow
);
  logic [EC_W-1:0] edgeMod;
  always_ff @(posedge clk) begin
    if (rst) edgeMod <= '0;
    else     edgeMod <= edgeMod + EC_W'(1);
  end

  p_txn_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (txnValid && !txnDone) |=> (txnValid && $stable({txnCmd, txnAddr, txnData, txnFault})));

  p_sync_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (headOp == OP_WSYNC && edgeMod != EC_W'(EDGES_PER_BUS - 1)) |=> $stable(pcNow));

  p_halt_no_txn_r8: assert property (@(posedge clk) disable iff (rst)
    endSim |-> !txnValid);

  p_peer_set_r12: assert property (@(posedge clk) disable iff (rst)
    (|peerSet) |=> ((syncFlags & $past(peerSet)) == $past(peerSet)));

  p_peer_clr_r12: assert property (@(posedge clk) disable iff (rst)
    (|(peerClr & ~peerSet)) |=> ((syncFlags & $past(peerClr & ~peerSet)) == '0));
endmodule

bind seqscript_top seqscript_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .txnValid(txnValid), .txnDone(txnDone),
  .txnCmd(txnCmd), .txnAddr(txnAddr), .txnData(txnData), .txnFault(txnFault),
  .endSim(endSim), .peerSet(peerSet), .peerClr(peerClr),
  .syncFlags(syncFlags), .headOp(headOp), .pcNow(pcNow)
);

// File: tb/seqscript_top_tb_top.sv
module seqscript_top_tb_top;
  import seqscript_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txnDone;
  logic [7:0] peerSet = '0;
  logic [7:0] peerClr = '0;
  logic txnValid, endSim, busMode;
  logic [3:0] txnCmd, byteSel;
  logic [15:0] txnAddr, txnData;
  logic [4:0] txnFault;
  logic [7:0] syncFlags;

  seqscript_top dut_i (
    .clk(clk), .rst(rst), .txnDone(txnDone), .peerSet(peerSet), .peerClr(peerClr),
    .txnValid(txnValid), .txnCmd(txnCmd), .txnAddr(txnAddr), .txnData(txnData),
    .txnFault(txnFault), .endSim(endSim), .busMode(busMode), .byteSel(byteSel),
    .syncFlags(syncFlags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int ecnt = 0;
  always @(posedge clk) if (!rst) ecnt <= ecnt + 1;

  typedef struct { logic [3:0] cmd; logic [15:0] addr; logic [15:0] data; logic [4:0] fault; } exp_t;
  exp_t expQ[$];
  int obsEdge [4];
  int nSeen = 0;
  int nChk = 0;
  int nFail = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  function automatic insn_t mk(input logic [3:0] op, input logic [2:0] fidx, input logic [3:0] cmd,
                               input logic [4:0] fault, input logic [15:0] addr, input logic [15:0] data);
    insn_t w;
    w.op = op; w.fidx = fidx; w.cmd = cmd; w.fault = fault; w.addr = addr; w.data = data;
    return w;
  endfunction

  task automatic pushExp(input logic [3:0] cmd, input logic [15:0] addr, input logic [15:0] data, input logic [4:0] fault);
    exp_t e;
    e.cmd = cmd; e.addr = addr; e.data = data; e.fault = fault;
    expQ.push_back(e);
  endtask

  task automatic stepN();
    @(negedge clk);
    #1;
  endtask

  // monitor: pops expectations, answers with txnDone (first one stalled two cycles)
  initial begin
    txnDone = 1'b0;
    forever begin
      @(negedge clk);
      txnDone = 1'b0;
      if (!rst && txnValid) begin
        if (expQ.size() == 0) begin
          chk("R2 unexpected transaction addr", txnAddr, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk("R2 txn cmd", txnCmd, e.cmd);
          chk("R2 txn addr (R5/R9 skipped words absent)", txnAddr, e.addr);
          chk("R2 txn data", txnData, e.data);
          chk("R2 txn fault", txnFault, e.fault);
        end
        if (nSeen < 4) obsEdge[nSeen] = ecnt;
        nSeen++;
        if (nSeen == 1) begin
          for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            chk("R2 held during stall valid", txnValid, 1);
            chk("R2 held during stall addr", txnAddr, 16'h1234);
          end
        end
        txnDone = 1'b1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n, p, q;
    #1;
    dut_i.u_dp.progMem[0]  = mk(OP_MODE,  0, 0, 0, 0, 16'd1);
    dut_i.u_dp.progMem[1]  = mk(OP_BSEL,  0, 0, 0, 0, 16'hA);
    dut_i.u_dp.progMem[2]  = mk(OP_XACT,  0, 4'd8, 5'd0, 16'h1234, 16'h5678);
    dut_i.u_dp.progMem[3]  = mk(OP_SETF,  3'd2, 0, 0, 0, 0);
    dut_i.u_dp.progMem[4]  = mk(OP_SKIPT, 3'd2, 0, 0, 0, 0);
    dut_i.u_dp.progMem[5]  = mk(OP_XACT,  0, 4'd9, 0, 16'hDEAD, 0);
    dut_i.u_dp.progMem[6]  = mk(OP_SKIPT, 3'd5, 0, 0, 0, 0);
    dut_i.u_dp.progMem[7]  = mk(OP_JUMP,  0, 0, 0, 0, 16'd9);
    dut_i.u_dp.progMem[8]  = mk(OP_XACT,  0, 4'd9, 0, 16'h0BAD, 0);
    dut_i.u_dp.progMem[9]  = mk(OP_XACT,  0, 4'd12, 5'd17, 16'h0042, 16'h0001);
    dut_i.u_dp.progMem[10] = mk(OP_WAIT,  0, 0, 0, 0, 16'd3);
    dut_i.u_dp.progMem[11] = mk(OP_XACT,  0, 4'd13, 5'd0, 16'h0100, 16'h00FF);
    dut_i.u_dp.progMem[12] = mk(OP_CLRF,  3'd2, 0, 0, 0, 0);
    dut_i.u_dp.progMem[13] = mk(4'd15,    3'd3, 4'd7, 5'd1, 16'hFFFF, 16'hFFFF);
    dut_i.u_dp.progMem[14] = mk(OP_WSYNC, 3'd4, 0, 0, 0, 0);
    dut_i.u_dp.progMem[15] = mk(OP_XACT,  0, 4'd15, 5'd3, 16'h0200, 16'h0002);
    dut_i.u_dp.progMem[16] = mk(OP_STOP,  0, 0, 0, 0, 0);
    dut_i.u_dp.progMem[17] = mk(OP_MODE,  0, 0, 0, 0, 16'd0);
    dut_i.u_dp.progMem[18] = mk(OP_SETF,  3'd1, 0, 0, 0, 0);
    dut_i.u_dp.progMem[19] = mk(OP_SETF,  3'd6, 0, 0, 0, 0);
    dut_i.u_dp.progMem[20] = mk(OP_CLRF,  3'd6, 0, 0, 0, 0);
    dut_i.u_dp.progMem[21] = mk(OP_SETF,  3'd7, 0, 0, 0, 0);
    dut_i.u_dp.progMem[22] = mk(OP_JUMP,  0, 0, 0, 0, 16'd22);
    pushExp(4'd8,  16'h1234, 16'h5678, 5'd0);
    pushExp(4'd12, 16'h0042, 16'h0001, 5'd17);
    pushExp(4'd13, 16'h0100, 16'h00FF, 5'd0);
    pushExp(4'd15, 16'h0200, 16'h0002, 5'd3);

    repeat (3) stepN();
    chk("R1 reset txnValid", txnValid, 0);
    chk("R1 reset endSim", endSim, 0);
    chk("R1 reset busMode", busMode, 0);
    chk("R1 reset byteSel", byteSel, 0);
    chk("R1 reset syncFlags", syncFlags, 0);
    rst = 1'b0;

    while (nSeen < 1) stepN();
    chk("R1 first txn on edge 1", obsEdge[0], 1);
    chk("R7 busMode after chain", busMode, 1);
    chk("R7 byteSel after chain", byteSel, 4'hA);

    while (nSeen < 2) stepN();
    chk("R11 R9 four-word chain in one cycle", obsEdge[1] - obsEdge[0], 4);
    chk("R6 flag 2 set", syncFlags, 8'h04);

    while (nSeen < 3) stepN();
    chk("R3 wait of 3 bus cycles", obsEdge[2] - obsEdge[1], 14);

    for (int i = 0; i < 6; i++) begin
      stepN();
      chk("R4 flag wait holds while flag clear", txnValid, 0);
    end
    chk("R6 flag 2 cleared", syncFlags, 8'h00);
    chk("R10 unknown word leaves busMode", busMode, 1);
    chk("R10 unknown word leaves byteSel", byteSel, 4'hA);

    n = ecnt;
    peerSet = 8'h10;
    stepN();
    peerSet = 8'h00;
    p = n + 1;
    q = p + 1;
    while (q % 4 != 0) q++;
    while (nSeen < 4) stepN();
    chk("R4 flag wait release edge", obsEdge[3], q);
    chk("R12 peer set flag 4", syncFlags, 8'h10);
    chk("R8 no halt before marker", endSim, 0);

    stepN();
    chk("R8 halt marker raised", endSim, 1);
    stepN();
    chk("R8 halt marker one cycle", endSim, 0);
    chk("R7 busMode not yet changed", busMode, 1);
    stepN();
    chk("R11 chain bound flags", syncFlags, 8'h12);
    chk("R7 busMode cleared", busMode, 0);
    stepN();
    chk("R11 remainder next cycle flags", syncFlags, 8'h92);
    repeat (3) stepN();
    chk("R9 parked on self jump flags", syncFlags, 8'h92);
    chk("R9 parked no transaction", txnValid, 0);

    peerSet = 8'h01;
    peerClr = 8'h81;
    stepN();
    peerSet = 8'h00;
    peerClr = 8'h00;
    chk("R12 set wins and clear applies", syncFlags, 8'h13);

    repeat (2) stepN();
    summary();
    $finish;
  end
endmodule